// File: doc/BRIEF.md
# Addressable RGB Pixel Line Encoder

This block turns a stream of 24-bit colour words into the one-wire pulse train that chained RGB LEDs expect. Each data bit goes out as a high pulse followed by a low pulse. The high and low lengths are counted in module-clock cycles, and a "1" bit has its own pair of lengths, separate from the pair for a "0" bit. Before a word is sent, a selectable order mode rearranges its three colour bytes. The bits of the rearranged word then go out most significant first.

A transfer begins with a start strobe while the block is idle. At that strobe the block captures the pixel count, the order mode, the four bit-phase lengths and the reset-gap length. It then takes exactly that many pixels through a valid/ready handshake. After the last bit it holds the line low for the gap and then pulses `done`. If the next pixel is late, the line stays low until it arrives and a sticky flag records the underrun.

Top module: `pixline_encoder`

## Requirements
- R1: A "1" bit drives the line high for `one_hi_cyc` cycles, then low for `one_lo_cyc` cycles. A "0" bit uses `zero_hi_cyc` and `zero_lo_cyc` in the same way. A programmed length of 0 acts as 1 cycle.
- R2: The input word carries channel A in bits 23:16, channel B in bits 15:8 and channel C in bits 7:0. The rearranged 24-bit word is sent from its bit 23 down to bit 0.
- R3: The order mode selects the order in which channels are sent. The values are 0=A,B,C; 1=A,C,B; 2=B,A,C; 3=B,C,A; 4=C,A,B; 5=C,B,A. Values 6 and 7 behave as mode 2.
- R4: A start strobe is accepted only while `busy` is low. When accepted, it captures the pixel count, order mode, bit lengths and gap length. Any later change to those inputs, and any start strobe raised while `busy` is high, has no effect on the transfer in progress.
- R5: A transfer sends exactly `pixel_total` pixels. `pix_ready` is high in two cases: during the last low cycle of a pixel when more pixels remain, and in every cycle while the block waits for a pixel. It is low at all other times.
- R6: After the final low phase, the line stays low for `gap_cyc` cycles (0 acts as 1). In the next cycle `done` is high for exactly one cycle and `busy` is already low.
- R7: A start with `pixel_total` = 0 produces only the low gap followed by the `done` pulse.
- R8: If no pixel is offered in the last low cycle of a pixel while more remain, the line stays low until a pixel is accepted and `underrun` becomes 1. `underrun` then stays 1 until the next accepted start clears it.
- R9: The line is low outside high phases. In reset, `line_out`, `pix_ready`, `busy`, `done` and `underrun` are all 0.
- R10: An accepted pixel starts its first high phase in the very next cycle. This holds both when it was accepted back to back in a final low cycle and when it was accepted after a wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all lengths count its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| order_mode | input | 3 | Channel order select |
| pixel_total | input | LEN_W (13) | Pixels in the transfer |
| one_hi_cyc | input | ONE_HI_W (6) | High length of a "1" bit |
| one_lo_cyc | input | ONE_LO_W (5) | Low length of a "1" bit |
| zero_hi_cyc | input | ZERO_HI_W (5) | High length of a "0" bit |
| zero_lo_cyc | input | ZERO_LO_W (6) | Low length of a "0" bit |
| gap_cyc | input | GAP_W (17) | Low gap after the last pixel |
| pix_valid | input | 1 | Pixel word offered |
| pix_data | input | 3*CH_W (24) | Pixel word, channels A/B/C from the top byte down |
| pix_ready | output | 1 | Pixel word taken this cycle if valid |
| line_out | output | 1 | Serial LED line |
| busy | output | 1 | Transfer or gap in progress |
| done | output | 1 | One-cycle pulse after the gap |
| underrun | output | 1 | Sticky late-pixel flag |

## Verification
Two things can fall in the same cycle: accepting the next pixel, and finishing the previous pixel's last low phase. If they line up, the next high phase follows with no extra cycle. If they miss by one cycle, the encoder instead goes into a wait with an underrun. The bench provokes both outcomes on purpose. It holds `pix_valid` high before `pix_ready` rises, it stalls for less than a pixel's length, and it stalls for longer than a pixel's length. A queue-based reference model predicts the line level, handshake, busy, done and underrun for every cycle, and the bench compares them at each falling edge, so an extra or missing cycle at the handover shows up at once.

// File: rtl/pixline_pkg.sv
package pixline_pkg;

   localparam int NUM_CH = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_HIGH,
      ST_LOW,
      ST_GAP
   } enc_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pixline_reorder.sv
module pixline_reorder
   import pixline_pkg::*;
#(
   parameter int CH_W          = 8,
   parameter int DEFAULT_ORDER = 2
) (
   input  logic [2:0]             mode,
   input  logic [NUM_CH*CH_W-1:0] pix_in,
   output logic [NUM_CH*CH_W-1:0] pix_out
);

   logic [CH_W-1:0] ch  [NUM_CH];
   logic [1:0]      src [NUM_CH];
   logic [2:0]      eff_mode;

   always_comb begin
      eff_mode = (mode > 3'd5) ? 3'(DEFAULT_ORDER) : mode;
      case (eff_mode)
         3'd0:    begin src[0] = 2'd0; src[1] = 2'd1; src[2] = 2'd2; end
         3'd1:    begin src[0] = 2'd0; src[1] = 2'd2; src[2] = 2'd1; end
         3'd3:    begin src[0] = 2'd1; src[1] = 2'd2; src[2] = 2'd0; end
         3'd4:    begin src[0] = 2'd2; src[1] = 2'd0; src[2] = 2'd1; end
         3'd5:    begin src[0] = 2'd2; src[1] = 2'd1; src[2] = 2'd0; end
         default: begin src[0] = 2'd1; src[1] = 2'd0; src[2] = 2'd2; end
      endcase
   end

   // slot 0 is the most significant byte of both words (sent first)
   for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
      assign ch[k] = pix_in[(NUM_CH-k)*CH_W-1 -: CH_W];
      assign pix_out[(NUM_CH-k)*CH_W-1 -: CH_W] = ch[src[k]];
   end

endmodule

// File: rtl/pixline_phase_timer.sv
module pixline_phase_timer #(
   parameter int W = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R1: once the count has run out it stays out until reloaded
   assert_hold_expired_R1: assert property (@(posedge clk) disable iff (!rst_n)
      expired && !load |=> expired);

endmodule

// File: rtl/pixline_encoder.sv
module pixline_encoder
   import pixline_pkg::*;
#(
   parameter int CH_W          = 8,
   parameter int ONE_HI_W      = 6,
   parameter int ONE_LO_W      = 5,
   parameter int ZERO_HI_W     = 5,
   parameter int ZERO_LO_W     = 6,
   parameter int GAP_W         = 17,
   parameter int LEN_W         = 13,
   parameter int DEFAULT_ORDER = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [2:0]             order_mode,
   input  logic [LEN_W-1:0]       pixel_total,
   input  logic [ONE_HI_W-1:0]    one_hi_cyc,
   input  logic [ONE_LO_W-1:0]    one_lo_cyc,
   input  logic [ZERO_HI_W-1:0]   zero_hi_cyc,
   input  logic [ZERO_LO_W-1:0]   zero_lo_cyc,
   input  logic [GAP_W-1:0]       gap_cyc,
   input  logic                   pix_valid,
   input  logic [NUM_CH*CH_W-1:0] pix_data,
   output logic                   pix_ready,
   output logic                   line_out,
   output logic                   busy,
   output logic                   done,
   output logic                   underrun
);

   localparam int PIX_W = NUM_CH * CH_W;
   localparam int IDX_W = $clog2(PIX_W);
   localparam int TMR_W = max_int(max_int(max_int(ONE_HI_W, ONE_LO_W),
                                          max_int(ZERO_HI_W, ZERO_LO_W)), GAP_W);

   if (CH_W < 1) begin : g_bad_ch
      $error("CH_W must be at least 1");
   end
   if (DEFAULT_ORDER < 0 || DEFAULT_ORDER > 5) begin : g_bad_order
      $error("DEFAULT_ORDER must lie in 0..5");
   end
   if (LEN_W < 1 || GAP_W < 1) begin : g_bad_len
      $error("LEN_W and GAP_W must be positive");
   end

   enc_state_e           st, st_n;
   logic [2:0]           cfg_mode;
   logic [ONE_HI_W-1:0]  cfg_one_hi;
   logic [ONE_LO_W-1:0]  cfg_one_lo;
   logic [ZERO_HI_W-1:0] cfg_zero_hi;
   logic [ZERO_LO_W-1:0] cfg_zero_lo;
   logic [GAP_W-1:0]     cfg_gap;
   logic [LEN_W-1:0]     left;
   logic [PIX_W-1:0]     word, word_in;
   logic [IDX_W-1:0]     bit_idx;
   logic                 tmr_load, tmr_expired;
   logic [TMR_W-1:0]     ld_raw, ld_val;
   logic                 start_ok, low_end, last_bit, more, take;

   pixline_reorder #(.CH_W(CH_W), .DEFAULT_ORDER(DEFAULT_ORDER)) u_reorder (
      .mode    (cfg_mode),
      .pix_in  (pix_data),
      .pix_out (word_in)
   );

   pixline_phase_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (ld_val),
      .expired  (tmr_expired)
   );

   function automatic logic [TMR_W-1:0] hi_len(input logic b);
      return b ? TMR_W'(cfg_one_hi) : TMR_W'(cfg_zero_hi);
   endfunction

   function automatic logic [TMR_W-1:0] lo_len(input logic b);
      return b ? TMR_W'(cfg_one_lo) : TMR_W'(cfg_zero_lo);
   endfunction

   assign start_ok  = (st == ST_IDLE) && start;
   assign low_end   = (st == ST_LOW) && tmr_expired;
   assign last_bit  = (bit_idx == '0);
   assign more      = (left > LEN_W'(1));
   assign pix_ready = (st == ST_FETCH) || (low_end && last_bit && more);
   assign take      = pix_ready && pix_valid;

   always_comb begin
      st_n     = st;
      tmr_load = 1'b0;
      ld_raw   = '0;
      case (st)
         ST_IDLE: if (start) begin
            if (pixel_total == '0) begin
               st_n = ST_GAP; tmr_load = 1'b1; ld_raw = TMR_W'(gap_cyc);
            end else begin
               st_n = ST_FETCH;
            end
         end
         ST_FETCH: if (pix_valid) begin
            st_n = ST_HIGH; tmr_load = 1'b1; ld_raw = hi_len(word_in[PIX_W-1]);
         end
         ST_HIGH: if (tmr_expired) begin
            st_n = ST_LOW; tmr_load = 1'b1; ld_raw = lo_len(word[PIX_W-1]);
         end
         ST_LOW: if (tmr_expired) begin
            if (!last_bit) begin
               st_n = ST_HIGH; tmr_load = 1'b1; ld_raw = hi_len(word[PIX_W-2]);
            end else if (more) begin
               if (pix_valid) begin
                  st_n = ST_HIGH; tmr_load = 1'b1; ld_raw = hi_len(word_in[PIX_W-1]);
               end else begin
                  st_n = ST_FETCH;
               end
            end else begin
               st_n = ST_GAP; tmr_load = 1'b1; ld_raw = TMR_W'(cfg_gap);
            end
         end
         ST_GAP: if (tmr_expired) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
      ld_val = (ld_raw == '0) ? '0 : ld_raw - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         done     <= 1'b0;
         underrun <= 1'b0;
         left     <= '0;
         word     <= '0;
         bit_idx  <= '0;
      end else begin
         st   <= st_n;
         done <= (st == ST_GAP) && tmr_expired;
         if (start_ok)
            underrun <= 1'b0;
         else if (low_end && last_bit && more && !pix_valid)
            underrun <= 1'b1;
         if (start_ok)
            left <= pixel_total;
         else if (low_end && last_bit && left != '0)
            left <= left - 1'b1;
         if (take) begin
            word    <= word_in;
            bit_idx <= IDX_W'(PIX_W - 1);
         end else if (low_end && !last_bit) begin
            word    <= {word[PIX_W-2:0], 1'b0};
            bit_idx <= bit_idx - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_mode    <= 3'(DEFAULT_ORDER);
         cfg_one_hi  <= '0;
         cfg_one_lo  <= '0;
         cfg_zero_hi <= '0;
         cfg_zero_lo <= '0;
         cfg_gap     <= '0;
      end else if (start_ok) begin
         cfg_mode    <= order_mode;
         cfg_one_hi  <= one_hi_cyc;
         cfg_one_lo  <= one_lo_cyc;
         cfg_zero_hi <= zero_hi_cyc;
         cfg_zero_lo <= zero_lo_cyc;
         cfg_gap     <= gap_cyc;
      end
   end

   assign busy     = (st != ST_IDLE);
   assign line_out = (st == ST_HIGH);

   assert_ready_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ready |-> busy);
   assert_take_goes_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && pix_ready |=> line_out);
   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy) && !busy);
   assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      underrun && !start |=> underrun);
   assert_busy_from_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

// File: tb/pixline_encoder_tb_top.sv
module pixline_encoder_tb_top;

   logic        clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, start, valid;
   logic [2:0]  mode;
   logic [12:0] total;
   logic [5:0]  t1h, t0l;
   logic [4:0]  t1l, t0h;
   logic [16:0] gap;
   logic [23:0] data;
   logic        ready, line, busy, done, und;

   pixline_encoder dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .order_mode(mode),
      .pixel_total(total), .one_hi_cyc(t1h), .one_lo_cyc(t1l),
      .zero_hi_cyc(t0h), .zero_lo_cyc(t0l), .gap_cyc(gap),
      .pix_valid(valid), .pix_data(data), .pix_ready(ready),
      .line_out(line), .busy(busy), .done(done), .underrun(und)
   );

   int    checks = 0, failures = 0;
   string tag = "R9";

   // reference model: one queue entry per future cycle
   // 0 = pixel low, 1 = pixel high, 3 = gap low, 2 = done cycle
   int q[$];
   int m_left = 0, m_mode, m1h, m1l, m0h, m0l, m_gap;
   bit m_und = 0, e_line = 0, e_ready = 0, e_busy = 0, e_done = 0;

   function automatic int atleast1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   function automatic logic [23:0] arrange(input logic [23:0] d, input int m);
      logic [7:0] a, b, c;
      a = d[23:16]; b = d[15:8]; c = d[7:0];
      case (m)
         0: return {a, b, c};
         1: return {a, c, b};
         3: return {b, c, a};
         4: return {c, a, b};
         5: return {c, b, a};
         default: return {b, a, c};
      endcase
   endfunction

   task automatic push_gap();
      for (int i = 0; i < atleast1(m_gap); i++) q.push_back(3);
      q.push_back(2);
   endtask

   task automatic push_pixel(input logic [23:0] d);
      logic [23:0] w;
      w = arrange(d, m_mode);
      for (int b = 23; b >= 0; b--) begin
         for (int i = 0; i < atleast1(w[b] ? m1h : m0h); i++) q.push_back(1);
         for (int i = 0; i < atleast1(w[b] ? m1l : m0l); i++) q.push_back(0);
      end
   endtask

   always @(posedge clk) begin
      bit hs, acc;
      int f;
      if (!rst_n) begin
         q.delete(); m_left = 0; m_und = 0;
         e_line = 0; e_ready = 0; e_busy = 0; e_done = 0;
      end else begin
         hs  = e_ready && valid;
         acc = start && !e_busy;
         if (m_left > 0 && q.size() == 1 && !valid) m_und = 1;
         if (q.size() > 0) void'(q.pop_front());
         if (acc) begin
            m_mode = mode; m1h = t1h; m1l = t1l; m0h = t0h; m0l = t0l; m_gap = gap;
            m_left = total; m_und = 0;
            if (total == 0) push_gap();
         end
         if (hs) begin
            push_pixel(data);
            m_left--;
            if (m_left == 0) push_gap();
         end
         f       = (q.size() > 0) ? q[0] : -1;
         e_line  = (f == 1);
         e_done  = (f == 2);
         e_busy  = (m_left > 0) || f == 0 || f == 1 || f == 3;
         e_ready = (m_left > 0) && (q.size() <= 1);
      end
   end

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0b expected=%0b time=%0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(line,  e_line,  tag,  "line_out");
         chk(ready, e_ready, "R5", "pix_ready");
         chk(busy,  e_busy,  "R6", "busy");
         chk(done,  e_done,  "R6", "done");
         chk(und,   m_und,   "R8", "underrun");
      end
   end

   // called at a falling edge; returns at a falling edge
   task automatic feed(input logic [23:0] d, input int stall);
      valid = 1'b0;
      repeat (stall) @(negedge clk);
      valid = 1'b1; data = d;
      while (!ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      valid = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int k = 0;
      while (!done && k < 100000) begin @(negedge clk); k++; end
      repeat (2) @(negedge clk);
   endtask

   task automatic frame(input int n, input int stall_at, input int stall_len,
                        input logic [23:0] seed);
      total = 13'(n);
      pulse_start();
      for (int i = 0; i < n; i++)
         feed(seed + 24'(i) * 24'h0a1b2c, (i == stall_at) ? stall_len : 0);
      wait_done();
   endtask

   task automatic set_times(input int a, input int b, input int c, input int d, input int g);
      t1h = 6'(a); t1l = 5'(b); t0h = 5'(c); t0l = 6'(d); gap = 17'(g);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      failures++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; valid = 1'b0; data = '0;
      mode = 3'd2; total = 13'd1;
      set_times(4, 2, 2, 4, 10);
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(line,  1'b0, "R9", "line_out in reset");
      chk(ready, 1'b0, "R9", "pix_ready in reset");
      chk(busy,  1'b0, "R9", "busy in reset");
      chk(done,  1'b0, "R9", "done in reset");
      chk(und,   1'b0, "R9", "underrun in reset");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 R2 R10: back-to-back pixels, default order
      tag = "R10";
      frame(3, -1, 0, 24'hf05a3c);

      // R3: every order mode, including the two spare codes
      tag = "R3";
      set_times(4, 2, 2, 4, 3);
      for (int m = 0; m < 8; m++) begin
         mode = 3'(m);
         frame(1, -1, 0, 24'hc3_81_1e);
      end
      mode = 3'd2;

      // R1 R6: zero lengths act as one cycle
      tag = "R1";
      set_times(0, 0, 0, 0, 0);
      frame(2, -1, 0, 24'h5aa5ff);

      // R1: widest lengths, asymmetric
      set_times(63, 31, 31, 63, 5);
      frame(1, -1, 0, 24'h9c0f71);

      // R7: empty transfer
      tag = "R7";
      set_times(3, 2, 2, 3, 7);
      frame(0, -1, 0, 24'h0);

      // R8: late pixel, then a short stall that is not late
      tag = "R8";
      set_times(2, 2, 2, 2, 4);
      frame(3, 1, 200, 24'h123456);
      frame(3, 1, 40, 24'h654321);   // start clears the sticky flag

      // R4: settings and start changed during a transfer are ignored
      tag = "R4";
      mode = 3'd5; set_times(3, 2, 2, 3, 6);
      total = 13'd2;
      pulse_start();
      feed(24'habcdef, 0);
      mode = 3'd0; set_times(9, 9, 9, 9, 30); total = 13'd5;
      pulse_start();
      feed(24'h13579b, 0);
      wait_done();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule